// File: doc/BRIEF.md
# Display configuration command decoder

This block sits behind the host byte interface of a dot-matrix display controller. Each accepted command byte either updates one of the controller's configuration registers at once, or arms a pending target so that the next accepted byte is taken as that register's value. The registers cover the settings the scan and drive logic consume: contrast level, first RAM line shown, segment and common direction, forced-on and inverted pixel modes, multiplex ratio, display offset, clock divider, charge periods, common pin arrangement, common deselect level, converter enable and display enable.

The block also builds the host-readable status byte, derives the supply mode from display enable and converter enable, and resolves the final lit state of one pixel from a RAM bit, so that a forced-on display wins over inverse video. A busy flag guards the decoder: it is high for a fixed number of cycles after reset is released and for the single cycle after any accepted byte, and bytes offered while it is high are dropped.

Top module: `dcfg_decoder`

## Requirements
- R1: While reset is applied, and after it, the registers hold contrast 0x80, start line 0, segment remap 0, forced-on 0, inverse 0, multiplex 0x3F, converter enable 1, display enable 0, common reverse 0, offset 0, clock divide 0x50, charge periods 0x22, common configuration 0x12, deselect level 0x35.
- R2: A byte in 0x40..0x7F sets the start line to its low 6 bits.
- R3: Byte 0x81 arms contrast; the next accepted byte, whatever its value (including values that are opcodes), becomes the contrast and no other register changes meanwhile.
- R4: Bytes 0xA8, 0xD3, 0xD5, 0xD9, 0xDA, 0xDB and 0xAD each take the next accepted byte as data: low 6 bits to multiplex and offset, all 8 bits to clock divide, charge periods, common configuration and deselect level, and bit 0 to converter enable (0xAD).
- R5: Bit 0 of the byte sets the flag for these pairs: 0xA0/0xA1 segment remap, 0xA4/0xA5 forced-on, 0xA6/0xA7 inverse, 0xAE/0xAF display enable, 0x8A/0x8B converter enable.
- R6: Any byte in 0xC0..0xCF sets common reverse to its bit 3.
- R7: `pixel_lit` is 1 whenever forced-on is set; otherwise it equals `ram_bit` XOR inverse.
- R8: `status_byte` bit 7 is busy, bit 6 is 1 when the display is disabled, bits 5..0 are 0.
- R9: `power_mode` is 0 (sleep) when the display is disabled, 1 (external supply) when enabled with converter off, 2 (internal converter) when enabled with converter on.
- R10: After `rst_n` rises, busy stays high for SYNC_STAGES + BOOT_CYCLES clock edges; bytes offered during that time change nothing.
- R11: Every accepted byte raises busy for exactly the next cycle; a byte offered in that cycle is dropped.
- R12: 0xE3 and every other byte not listed in R2..R6 change no register and leave nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered this cycle |
| cmd_byte | input | 8 | Command or data byte |
| ram_bit | input | 1 | RAM pixel value to resolve |
| contrast | output | 8 | Contrast level |
| start_line | output | 6 | First RAM line shown |
| seg_remap | output | 1 | Segment direction reversed |
| entire_on | output | 1 | All pixels forced on |
| inverse | output | 1 | Inverse video |
| mux_ratio | output | 6 | Multiplex ratio minus one |
| dcdc_en | output | 1 | Internal converter enable |
| disp_on | output | 1 | Display enable |
| com_reverse | output | 1 | Common scan reversed |
| disp_offset | output | 6 | Vertical offset |
| clk_div | output | 8 | Clock divide and frequency |
| precharge | output | 8 | Discharge and precharge periods |
| com_cfg | output | 8 | Common pin configuration |
| vcom_level | output | 8 | Common deselect level |
| busy | output | 1 | Decoder busy |
| status_byte | output | 8 | Host status byte |
| power_mode | output | 2 | Supply mode |
| pixel_lit | output | 1 | Resolved pixel state |

## Verification
Two functions collide when a new byte arrives in the very cycle that busy is raised by the previous byte's application, and when a data byte for a pending two-byte command looks like an opcode. The bench drives bytes back to back on consecutive clocks and also sends every byte value as contrast data after 0x81. It judges the outcome only through the register ports: the second of two adjacent bytes must leave no trace, a pending target must survive the dropped byte, and an opcode-valued data byte must land in contrast with display enable untouched.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  localparam int DW     = 8;
  localparam int LINE_W = 6;

  typedef enum logic [3:0] {
    OP_NONE, OP_START, OP_CONTRAST, OP_MUX, OP_OFFSET, OP_CLKDIV,
    OP_PRECH, OP_COMCFG, OP_VCOM, OP_DCDC, OP_REMAP, OP_ENTIRE,
    OP_INVERSE, OP_DISP, OP_COMDIR
  } op_e;

  typedef enum logic [1:0] {
    PWR_SLEEP = 2'd0,
    PWR_EXT   = 2'd1,
    PWR_INT   = 2'd2
  } pwr_e;

  typedef struct packed {
    logic [DW-1:0]     contrast;
    logic [LINE_W-1:0] start;
    logic              remap;
    logic              entire;
    logic              inverse;
    logic [LINE_W-1:0] mux;
    logic              dcdc;
    logic              disp;
    logic              com_rev;
    logic [LINE_W-1:0] offset;
    logic [DW-1:0]     clkdiv;
    logic [DW-1:0]     prech;
    logic [DW-1:0]     comcfg;
    logic [DW-1:0]     vcom;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    contrast: 8'h80, start: 6'd0, remap: 1'b0, entire: 1'b0,
    inverse: 1'b0, mux: 6'h3F, dcdc: 1'b1, disp: 1'b0, com_rev: 1'b0,
    offset: 6'd0, clkdiv: 8'h50, prech: 8'h22, comcfg: 8'h12,
    vcom: 8'h35
  };
endpackage

// File: rtl/dcfg_seq.sv
module dcfg_seq
  import dcfg_pkg::*;
#(
  parameter int BOOT_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [DW-1:0] cmd_byte,
  output op_e           op_o,
  output logic [DW-1:0] data_o,
  output logic          busy_o
);
  localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BOOT_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             apply_q, apply_d;
  op_e              pend_q, pend_d;
  op_e              dec_op;
  logic             dec_two;
  logic             accept;

  assign busy_o = (cnt_q != '0) | apply_q;
  assign accept = cmd_valid & ~busy_o;
  assign data_o = cmd_byte;

  // opcode decode: target register and whether a data byte follows
  always_comb begin
    dec_op  = OP_NONE;
    dec_two = 1'b0;
    casez (cmd_byte)
      8'b01??????: dec_op = OP_START;
      8'h81:       begin dec_op = OP_CONTRAST; dec_two = 1'b1; end
      8'hA8:       begin dec_op = OP_MUX;      dec_two = 1'b1; end
      8'hD3:       begin dec_op = OP_OFFSET;   dec_two = 1'b1; end
      8'hD5:       begin dec_op = OP_CLKDIV;   dec_two = 1'b1; end
      8'hD9:       begin dec_op = OP_PRECH;    dec_two = 1'b1; end
      8'hDA:       begin dec_op = OP_COMCFG;   dec_two = 1'b1; end
      8'hDB:       begin dec_op = OP_VCOM;     dec_two = 1'b1; end
      8'hAD:       begin dec_op = OP_DCDC;     dec_two = 1'b1; end
      8'h8A, 8'h8B: dec_op = OP_DCDC;
      8'hA0, 8'hA1: dec_op = OP_REMAP;
      8'hA4, 8'hA5: dec_op = OP_ENTIRE;
      8'hA6, 8'hA7: dec_op = OP_INVERSE;
      8'hAE, 8'hAF: dec_op = OP_DISP;
      8'b1100????: dec_op = OP_COMDIR;
      default:     dec_op = OP_NONE;
    endcase
  end

  // next state
  always_comb begin
    op_o    = OP_NONE;
    pend_d  = pend_q;
    apply_d = accept;
    cnt_d   = (cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
    if (accept) begin
      if (pend_q != OP_NONE) begin
        op_o   = pend_q;
        pend_d = OP_NONE;
      end else if (dec_two) begin
        pend_d = dec_op;
      end else begin
        op_o = dec_op;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_INIT;
      apply_q <= 1'b0;
      pend_q  <= OP_NONE;
    end else begin
      cnt_q   <= cnt_d;
      apply_q <= apply_d;
      pend_q  <= pend_d;
    end
  end

  // R11: an accepted byte raises busy in the next cycle
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  // R11: once boot is over, busy never lasts two cycles
  a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q == '0) |=> !busy_o);

  // R3: a data byte consumed for a pending target clears the pending state
  a_r3_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_q != OP_NONE) |=> pend_q == OP_NONE);

  // R10: the boot window counts down one per cycle
  a_r10_boot_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/dcfg_regs.sv
module dcfg_regs
  import dcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_i,
  input  logic [DW-1:0] data_i,
  output cfg_t          cfg_o
);
  cfg_t cfg_q, cfg_d;

  assign cfg_o = cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    case (op_i)
      OP_START:    cfg_d.start    = data_i[LINE_W-1:0];
      OP_CONTRAST: cfg_d.contrast = data_i;
      OP_MUX:      cfg_d.mux      = data_i[LINE_W-1:0];
      OP_OFFSET:   cfg_d.offset   = data_i[LINE_W-1:0];
      OP_CLKDIV:   cfg_d.clkdiv   = data_i;
      OP_PRECH:    cfg_d.prech    = data_i;
      OP_COMCFG:   cfg_d.comcfg   = data_i;
      OP_VCOM:     cfg_d.vcom     = data_i;
      OP_DCDC:     cfg_d.dcdc     = data_i[0];
      OP_REMAP:    cfg_d.remap    = data_i[0];
      OP_ENTIRE:   cfg_d.entire   = data_i[0];
      OP_INVERSE:  cfg_d.inverse  = data_i[0];
      OP_DISP:     cfg_d.disp     = data_i[0];
      OP_COMDIR:   cfg_d.com_rev  = data_i[3];
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  // R12: with no operation issued the register file holds its contents
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE) |=> $stable(cfg_q));
endmodule

// File: rtl/dcfg_view.sv
module dcfg_view
  import dcfg_pkg::*;
(
  input  logic          disp_on,
  input  logic          dcdc_en,
  input  logic          entire_on,
  input  logic          inverse,
  input  logic          busy,
  input  logic          ram_bit,
  output logic [DW-1:0] status_o,
  output logic [1:0]    power_o,
  output logic          lit_o
);
  pwr_e pwr;

  always_comb begin
    if (!disp_on)     pwr = PWR_SLEEP;
    else if (dcdc_en) pwr = PWR_INT;
    else              pwr = PWR_EXT;
  end

  assign power_o  = pwr;
  assign status_o = {busy, ~disp_on, {(DW-2){1'b0}}};
  assign lit_o    = entire_on | (ram_bit ^ inverse);
endmodule

// File: rtl/dcfg_decoder.sv
module dcfg_decoder
  import dcfg_pkg::*;
#(
  parameter int BOOT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          ram_bit,
  output logic [7:0]    contrast,
  output logic [5:0]    start_line,
  output logic          seg_remap,
  output logic          entire_on,
  output logic          inverse,
  output logic [5:0]    mux_ratio,
  output logic          dcdc_en,
  output logic          disp_on,
  output logic          com_reverse,
  output logic [5:0]    disp_offset,
  output logic [7:0]    clk_div,
  output logic [7:0]    precharge,
  output logic [7:0]    com_cfg,
  output logic [7:0]    vcom_level,
  output logic          busy,
  output logic [7:0]    status_byte,
  output logic [1:0]    power_mode,
  output logic          pixel_lit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_core_n;
  op_e                    op;
  logic [DW-1:0]          data;
  cfg_t                   cfg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = sync_q[SYNC_STAGES-1];

  dcfg_seq #(.BOOT_CYCLES(BOOT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .op_o(op), .data_o(data), .busy_o(busy)
  );

  dcfg_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .op_i(op), .data_i(data), .cfg_o(cfg)
  );

  dcfg_view u_view (
    .disp_on(cfg.disp), .dcdc_en(cfg.dcdc), .entire_on(cfg.entire),
    .inverse(cfg.inverse), .busy(busy), .ram_bit(ram_bit),
    .status_o(status_byte), .power_o(power_mode), .lit_o(pixel_lit)
  );

  assign contrast    = cfg.contrast;
  assign start_line  = cfg.start;
  assign seg_remap   = cfg.remap;
  assign entire_on   = cfg.entire;
  assign inverse     = cfg.inverse;
  assign mux_ratio   = cfg.mux;
  assign dcdc_en     = cfg.dcdc;
  assign disp_on     = cfg.disp;
  assign com_reverse = cfg.com_rev;
  assign disp_offset = cfg.offset;
  assign clk_div     = cfg.clkdiv;
  assign precharge   = cfg.prech;
  assign com_cfg     = cfg.comcfg;
  assign vcom_level  = cfg.vcom;

  // R10: a byte offered while busy leaves every register unchanged
  a_r10_reject_busy: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_valid && busy) |=> $stable(cfg));

  // R8: status on/off bit tracks a display enable change
  a_r8_status_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(disp_on) |-> $fell(status_byte[6]));

  // R9: a disabled display always reports sleep
  a_r9_sleep_when_off: assert property (@(posedge clk) disable iff (!rst_core_n)
    !disp_on |-> power_mode == 2'd0);

  // R7: forced-on overrides RAM content and inverse video
  a_r7_forced_on_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    entire_on |-> pixel_lit);
endmodule

// File: tb/sim_dcfg_decoder.sv
module sim_dcfg_decoder;
  localparam int BOOT = 16;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       ram_bit = 1'b0;
  logic [7:0] contrast, clk_div, precharge, com_cfg, vcom_level, status_byte;
  logic [5:0] start_line, mux_ratio, disp_offset;
  logic       seg_remap, entire_on, inverse, dcdc_en, disp_on, com_reverse;
  logic       busy, pixel_lit;
  logic [1:0] power_mode;

  always #5 clk = ~clk;

  dcfg_decoder #(.BOOT_CYCLES(BOOT), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ram_bit(ram_bit), .contrast(contrast), .start_line(start_line),
    .seg_remap(seg_remap), .entire_on(entire_on), .inverse(inverse),
    .mux_ratio(mux_ratio), .dcdc_en(dcdc_en), .disp_on(disp_on),
    .com_reverse(com_reverse), .disp_offset(disp_offset), .clk_div(clk_div),
    .precharge(precharge), .com_cfg(com_cfg), .vcom_level(vcom_level),
    .busy(busy), .status_byte(status_byte), .power_mode(power_mode),
    .pixel_lit(pixel_lit)
  );

  typedef struct packed {
    logic [7:0] contrast; logic [5:0] start; logic remap; logic entire;
    logic inverse; logic [5:0] mux; logic dcdc; logic disp; logic com_rev;
    logic [5:0] offset; logic [7:0] clkdiv; logic [7:0] prech;
    logic [7:0] comcfg; logic [7:0] vcom;
  } snap_t;

  localparam snap_t DEF = '{
    contrast: 8'h80, start: 6'd0, remap: 1'b0, entire: 1'b0, inverse: 1'b0,
    mux: 6'h3F, dcdc: 1'b1, disp: 1'b0, com_rev: 1'b0, offset: 6'd0,
    clkdiv: 8'h50, prech: 8'h22, comcfg: 8'h12, vcom: 8'h35
  };

  snap_t dut_s;
  assign dut_s = {contrast, start_line, seg_remap, entire_on, inverse,
                  mux_ratio, dcdc_en, disp_on, com_reverse, disp_offset,
                  clk_div, precharge, com_cfg, vcom_level};

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit takes_data(input logic [7:0] b);
    return b inside {8'h81, 8'hA8, 8'hD3, 8'hD5, 8'hD9, 8'hDA, 8'hDB, 8'hAD};
  endfunction

  function automatic snap_t model(input snap_t s, input logic [7:0] b,
                                  input logic [7:0] d);
    snap_t r = s;
    if (b[7:6] == 2'b01)          r.start   = b[5:0];
    else if (b == 8'h81)          r.contrast = d;
    else if (b == 8'hA8)          r.mux     = d[5:0];
    else if (b == 8'hD3)          r.offset  = d[5:0];
    else if (b == 8'hD5)          r.clkdiv  = d;
    else if (b == 8'hD9)          r.prech   = d;
    else if (b == 8'hDA)          r.comcfg  = d;
    else if (b == 8'hDB)          r.vcom    = d;
    else if (b == 8'hAD)          r.dcdc    = d[0];
    else if (b[7:1] == 7'h45)     r.dcdc    = b[0];
    else if (b[7:1] == 7'h50)     r.remap   = b[0];
    else if (b[7:1] == 7'h52)     r.entire  = b[0];
    else if (b[7:1] == 7'h53)     r.inverse = b[0];
    else if (b[7:1] == 7'h57)     r.disp    = b[0];
    else if (b[7:4] == 4'hC)      r.com_rev = b[3];
    return r;
  endfunction

  function automatic string req_of(input logic [7:0] b);
    if (b[7:6] == 2'b01) return "R2 start line";
    if (b == 8'h81) return "R3 contrast";
    if (takes_data(b)) return "R4 two-byte";
    if (b inside {[8'hA0:8'hA7], 8'hAE, 8'hAF, 8'h8A, 8'h8B}) return "R5 flag";
    if (b[7:4] == 4'hC) return "R6 scan direction";
    return "R12 ignored opcode";
  endfunction

  task automatic do_reset(input bit check_boot);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (check_boot) begin
      chk("R1 defaults in reset", dut_s, DEF);
      chk("R8 status in reset", status_byte, 8'hC0);
    end
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy && n < 200);
    if (check_boot) begin
      chk("R10 boot busy length", n, BOOT + SYNC);
      chk("R1 defaults after boot", dut_s, DEF);
      chk("R8 status idle", status_byte, 8'h40);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  // two bytes on consecutive clocks; the second lands while busy
  task automatic send_pair(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte = a;
    @(negedge clk);
    cmd_byte = b;
    chk("R11 busy after accept", busy, 1'b1);
    chk("R8 busy in status", status_byte[7], 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 busy one cycle", busy, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    snap_t exp;

    // R1, R8, R10 reset and boot
    do_reset(1'b1);

    // R10: bytes offered during boot are dropped
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cmd_valid = 1'b1;
    cmd_byte = 8'hAF;
    repeat (8) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R10 byte during boot ignored", dut_s, DEF);

    // sweep every opcode from the default state
    for (int b = 0; b < 256; b++) begin
      logic [7:0] op, dat;
      op = 8'(b);
      dat = op ^ 8'hA5;
      do_reset(1'b0);
      send(op);
      if (takes_data(op)) send(dat);
      exp = model(DEF, op, dat);
      chk(req_of(op), dut_s, exp);
      // nothing may remain pending: a display-on must now take effect
      send(8'hAF);
      exp.disp = 1'b1;
      chk({req_of(op), " no pending"}, dut_s, exp);
    end

    // R3: every value, opcodes included, lands in contrast
    do_reset(1'b0);
    for (int v = 0; v < 256; v++) begin
      send(8'h81);
      send(8'(v));
      exp = DEF;
      exp.contrast = 8'(v);
      chk("R3 contrast data value", dut_s, exp);
    end

    // R11: adjacent bytes, second dropped
    do_reset(1'b0);
    send_pair(8'hAF, 8'hA7);
    chk("R11 first applied", disp_on, 1'b1);
    chk("R11 second dropped", inverse, 1'b0);
    // R11 with R3: dropped byte does not consume the pending contrast
    send_pair(8'h81, 8'h55);
    chk("R11 contrast untouched", contrast, 8'h80);
    send(8'h33);
    chk("R3 pending survives drop", contrast, 8'h33);

    // R7 pixel resolution
    do_reset(1'b0);
    for (int e = 0; e < 2; e++) begin
      for (int i = 0; i < 2; i++) begin
        send(8'hA4 | 8'(e));
        send(8'hA6 | 8'(i));
        for (int r = 0; r < 2; r++) begin
          ram_bit = r[0];
          #1;
          chk("R7 pixel lit", pixel_lit, e[0] | (r[0] ^ i[0]));
        end
      end
    end

    // R8, R9 status and supply mode
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 2; c++) begin
        send(8'hAE | 8'(d));
        send(8'h8A | 8'(c));
        chk("R9 power mode", power_mode,
            d[0] ? (c[0] ? 2'd2 : 2'd1) : 2'd0);
        chk("R8 status byte", status_byte, {1'b0, ~d[0], 6'b0});
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule